// File: doc/BRIEF.md
# Booth and Signed-Digit Operand Encoder with Digit-Serial MAC

This block prepares a pair of 8-bit two's complement operands for a multiply-accumulate array and then runs the multiply itself, one digit pair at a time. The activation is recoded into signed radix-4 digits. Each digit in the range -2..+2 is read from a three-bit window that overlaps its neighbour by one bit. The weight is recoded into canonical signed-digit form: digits of -1, 0 or +1, with no two neighbouring digits both nonzero. Fewer nonzero digits means fewer partial products.

A start pulse captures both operands and registers their encoded digits. A small sequencer then walks every (activation digit, weight digit) pair. When both digits are nonzero it forms their product, shifts it by the pair's weight (x4 per activation digit position, x2 per weight digit position) and adds it to a signed accumulator. It also counts one add event. Pairs that contain a zero digit are skipped and add nothing.

A chain input keeps the previous sum, so a vector inner product is built one element pair per run. The event counter restarts with every run, so it reports the nonzero partial products of a single multiply.

Top module: `opEncMac`

## Requirements
- R1: After reset, busy, done, accOut, eventCnt, boothDigits and csdDigits are all zero.
- R2: On an accepted start, boothDigits holds 4 three-bit two's complement fields, with digit k in bits [3k+2:3k]. Digit k equals a[2k]+a[2k-1]-2*a[2k+1], taking a[-1]=0. Every digit lies in -2..+2, and the sum of digit k times 4^k equals the activation.
- R3: On an accepted start, csdDigits holds 8 two-bit fields, with digit i in bits [2i+1:2i], coded 01=+1, 11=-1, 00=0; code 10 never appears. The sum of digit i times 2^i equals the weight, and no two neighbouring digits are both nonzero.
- R4: A start accepted at one rising edge raises done right after the 32nd following rising edge. At that point accOut equals activation times weight when chain was 0.
- R5: eventCnt at done equals the number of nonzero activation digits times the number of nonzero weight digits. A run with a zero operand adds nothing and counts zero.
- R6: A start with chain=1 adds activation times weight to the previous accOut. eventCnt still restarts from zero.
- R7: A start raised while busy is ignored: the digits, the result and the timing of the running multiply are unchanged.
- R8: busy is high from the edge that accepts start until done rises. done lasts one cycle. Afterwards accOut, eventCnt and the digits hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when not busy |
| chain | input | 1 | 1: add to previous accOut; 0: clear it first |
| actIn | input | 8 | Activation, two's complement |
| wgtIn | input | 8 | Weight, two's complement |
| busy | output | 1 | Digit pairs are being processed |
| done | output | 1 | One-cycle pulse, result valid |
| accOut | output | 20 | Signed accumulator |
| eventCnt | output | 6 | Nonzero partial products in the last run |
| boothDigits | output | 12 | Registered radix-4 activation digits |
| csdDigits | output | 16 | Registered signed weight digits |

## Verification
A wrong encoder state shows up on boothDigits or csdDigits one cycle after the start edge, long before any arithmetic has run. The bench compares every field there against digit sets it computes by a separate method. A fault in the pair sequencer or accumulator shows up either in the cycle done rises or as a changed latency. The bench counts the cycles and compares accOut and eventCnt with the integer product and with the product of the nonzero digit counts. Chained runs and a start raised mid-run test the kept sum and the ignored request at the same done pulse.

// File: rtl/opEncPkg.sv
package opEncPkg;
  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic load;      // capture operands and encode
    logic clearAcc;  // zero the accumulator on load
    logic step;      // process the selected digit pair
  } strobe_t;
endpackage

// File: rtl/opEncCtrl.sv
module opEncCtrl
  import opEncPkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          chain,
  output strobe_t       strobe,
  output logic [RW-1:0] rowIdx,
  output logic [CW-1:0] colIdx,
  output logic          busy,
  output logic          done
);
  logic accept;
  logic lastCol;
  logic lastPair;

  always_comb begin
    accept         = start && !busy;
    lastCol        = (colIdx == CW'(COLS - 1));
    lastPair       = busy && lastCol && (rowIdx == RW'(ROWS - 1));
    strobe.load    = accept;
    strobe.clearAcc = accept && !chain;
    strobe.step    = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      rowIdx <= '0;
      colIdx <= '0;
    end else begin
      done <= lastPair;
      if (accept) begin
        busy   <= 1'b1;
        rowIdx <= '0;
        colIdx <= '0;
      end else if (busy) begin
        if (lastCol) begin
          colIdx <= '0;
          if (lastPair) busy <= 1'b0;
          else rowIdx <= rowIdx + RW'(1);
        end else begin
          colIdx <= colIdx + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/opEncDatapath.sv
module opEncDatapath
  import opEncPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W = 20,
  localparam int ROWS = DATA_W / 2,
  localparam int COLS = DATA_W,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CNT_W = $clog2(ROWS * COLS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [RW-1:0]           rowIdx,
  input  logic [CW-1:0]           colIdx,
  input  logic [DATA_W-1:0]       actIn,
  input  logic [DATA_W-1:0]       wgtIn,
  output logic [3*ROWS-1:0]       boothDigits,
  output logic [2*COLS-1:0]       csdDigits,
  output logic signed [ACC_W-1:0] accOut,
  output logic [CNT_W-1:0]        eventCnt
);
  logic [3*ROWS-1:0] boothNext, boothQ;
  logic [2*COLS-1:0] csdNext, csdQ;
  logic [DATA_W:0]   actPad;
  logic [DATA_W:0]   wgtExt;
  logic              carry, carryNext;

  // radix-4 windows over the activation, implicit zero below bit 0
  always_comb begin
    actPad    = {actIn, 1'b0};
    boothNext = '0;
    for (int k = 0; k < ROWS; k++) begin
      boothNext[3*k +: 3] = 3'(int'(actPad[2*k]) + int'(actPad[2*k+1])
                               - 2 * int'(actPad[2*k+2]));
    end
  end

  // single carry pass gives the non-adjacent signed-digit form
  always_comb begin
    wgtExt    = {wgtIn[DATA_W-1], wgtIn};
    carry     = 1'b0;
    carryNext = 1'b0;
    csdNext   = '0;
    for (int i = 0; i < COLS; i++) begin
      carryNext = (wgtExt[i] & wgtExt[i+1]) | (wgtExt[i] & carry)
                | (wgtExt[i+1] & carry);
      csdNext[2*i +: 2] = 2'(int'(wgtExt[i]) + int'(carry) - 2 * int'(carryNext));
      carry = carryNext;
    end
  end

  logic signed [2:0]       bDig;
  logic signed [1:0]       cDig;
  logic signed [3:0]       pairProd;
  logic signed [ACC_W-1:0] pairExt;
  logic signed [ACC_W-1:0] pairShifted;
  logic                    pairHit;

  always_comb begin
    bDig        = boothQ[3*rowIdx +: 3];
    cDig        = csdQ[2*colIdx +: 2];
    pairProd    = bDig * cDig;
    pairExt     = ACC_W'(pairProd);
    pairShifted = pairExt <<< (2 * int'(rowIdx) + int'(colIdx));
    pairHit     = (bDig != 3'sd0) && (cDig != 2'sd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boothQ   <= '0;
      csdQ     <= '0;
      accOut   <= '0;
      eventCnt <= '0;
    end else if (strobe.load) begin
      boothQ   <= boothNext;
      csdQ     <= csdNext;
      eventCnt <= '0;
      if (strobe.clearAcc) accOut <= '0;
    end else if (strobe.step && pairHit) begin
      accOut   <= accOut + pairShifted;
      eventCnt <= eventCnt + CNT_W'(1);
    end
  end

  assign boothDigits = boothQ;
  assign csdDigits   = csdQ;
endmodule

// File: rtl/opEncMac.sv
module opEncMac
  import opEncPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W = 20,
  localparam int ROWS = DATA_W / 2,
  localparam int COLS = DATA_W,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CNT_W = $clog2(ROWS * COLS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    chain,
  input  logic [DATA_W-1:0]       actIn,
  input  logic [DATA_W-1:0]       wgtIn,
  output logic                    busy,
  output logic                    done,
  output logic signed [ACC_W-1:0] accOut,
  output logic [CNT_W-1:0]        eventCnt,
  output logic [3*ROWS-1:0]       boothDigits,
  output logic [2*COLS-1:0]       csdDigits
);
  strobe_t       strobe;
  logic [RW-1:0] rowIdx;
  logic [CW-1:0] colIdx;

  opEncCtrl #(.ROWS(ROWS), .COLS(COLS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .chain(chain),
    .strobe(strobe), .rowIdx(rowIdx), .colIdx(colIdx),
    .busy(busy), .done(done)
  );

  opEncDatapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowIdx(rowIdx), .colIdx(colIdx),
    .actIn(actIn), .wgtIn(wgtIn), .boothDigits(boothDigits),
    .csdDigits(csdDigits), .accOut(accOut), .eventCnt(eventCnt)
  );
endmodule

// File: rtl/opEncMacChk.sv
module opEncMacChk #(
  parameter int DATA_W = 8,
  parameter int ACC_W = 20,
  localparam int ROWS = DATA_W / 2,
  localparam int COLS = DATA_W,
  localparam int CNT_W = $clog2(ROWS * COLS + 1)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic signed [ACC_W-1:0] accOut,
  input logic [CNT_W-1:0]        eventCnt,
  input logic [3*ROWS-1:0]       boothDigits,
  input logic [2*COLS-1:0]       csdDigits
);
  for (genvar k = 0; k < ROWS; k++) begin : gBooth
    // R2: digits stay within -2..+2
    a_r2_booth_range: assert property (@(posedge clk) disable iff (!rstN)
      (boothDigits[3*k +: 3] != 3'b011) && (boothDigits[3*k +: 3] != 3'b100));
  end

  for (genvar i = 0; i < COLS; i++) begin : gCsd
    // R3: code 10 is never produced
    a_r3_csd_code: assert property (@(posedge clk) disable iff (!rstN)
      csdDigits[2*i +: 2] != 2'b10);
  end

  for (genvar i = 0; i < COLS - 1; i++) begin : gAdj
    // R3: no two neighbouring nonzero digits
    a_r3_csd_nonadjacent: assert property (@(posedge clk) disable iff (!rstN)
      !((csdDigits[2*i +: 2] != 2'b00) && (csdDigits[2*i+2 +: 2] != 2'b00)));
  end

  // R4: an accepted start makes the block busy
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7: encoded operands do not move while a multiply runs
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(boothDigits) && $stable(csdDigits)));

  // R8: done is a single-cycle pulse outside busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: results hold while idle
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(accOut) && $stable(eventCnt)));
endmodule

bind opEncMac opEncMacChk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .accOut(accOut), .eventCnt(eventCnt), .boothDigits(boothDigits),
  .csdDigits(csdDigits)
);

// File: tb/tb_opEncMac.sv
module tb_opEncMac;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        chain = 1'b0;
  logic [7:0]  actIn = '0;
  logic [7:0]  wgtIn = '0;
  logic        busy, done;
  logic signed [19:0] accOut;
  logic [5:0]  eventCnt;
  logic [11:0] boothDigits;
  logic [15:0] csdDigits;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  longint expAcc = 0;

  opEncMac dut (
    .clk(clk), .rstN(rstN), .start(start), .chain(chain),
    .actIn(actIn), .wgtIn(wgtIn), .busy(busy), .done(done),
    .accOut(accOut), .eventCnt(eventCnt),
    .boothDigits(boothDigits), .csdDigits(csdDigits)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // radix-4 digits by table lookup on the doubled activation
  function automatic logic [11:0] boothRef(input logic [7:0] a);
    logic [11:0] r = '0;
    int dbl = int'($signed(a)) * 2;
    for (int k = 0; k < 4; k++) begin
      int w3 = (dbl >>> (2 * k)) & 7;
      int d;
      case (w3)
        1, 2: d = 1;
        3: d = 2;
        4: d = -2;
        5, 6: d = -1;
        default: d = 0;
      endcase
      r[3*k +: 3] = 3'(d);
    end
    return r;
  endfunction

  // non-adjacent form by repeated remainder mod 4
  function automatic logic [15:0] csdRef(input logic [7:0] w);
    logic [15:0] r = '0;
    int v = int'($signed(w));
    for (int i = 0; i < 8; i++) begin
      int d = 0;
      if (v % 2 != 0) begin
        d = 2 - (((v % 4) + 4) % 4);
        v = v - d;
      end
      r[2*i +: 2] = 2'(d);
      v = v / 2;
    end
    return r;
  endfunction

  function automatic int nzBooth(input logic [11:0] b);
    int n = 0;
    for (int k = 0; k < 4; k++) if (b[3*k +: 3] != 3'b000) n++;
    return n;
  endfunction

  function automatic int nzCsd(input logic [15:0] c);
    int n = 0;
    for (int i = 0; i < 8; i++) if (c[2*i +: 2] != 2'b00) n++;
    return n;
  endfunction

  function automatic int sumBooth(input logic [11:0] b);
    int s = 0;
    for (int k = 0; k < 4; k++) s += int'($signed(b[3*k +: 3])) * (4 ** k);
    return s;
  endfunction

  function automatic int sumCsd(input logic [15:0] c);
    int s = 0;
    for (int i = 0; i < 8; i++) s += int'($signed(c[2*i +: 2])) * (2 ** i);
    return s;
  endfunction

  // one multiply; optionally raises start mid-run with other operands (R7)
  task automatic runMac(input logic [7:0] a, input logic [7:0] w,
                        input bit ch, input bit inject);
    logic [11:0] eb = boothRef(a);
    logic [15:0] ec = csdRef(w);
    int n = 0;
    int expEv = nzBooth(eb) * nzCsd(ec);
    if (ch) expAcc = expAcc + longint'($signed(a)) * longint'($signed(w));
    else expAcc = longint'($signed(a)) * longint'($signed(w));
    @(negedge clk);
    actIn = a; wgtIn = w; chain = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
    check(boothDigits == eb, "R2 booth digits", longint'(boothDigits), longint'(eb));
    check(sumBooth(boothDigits) == int'($signed(a)), "R2 booth value",
          longint'(sumBooth(boothDigits)), longint'($signed(a)));
    check(csdDigits == ec, "R3 csd digits", longint'(csdDigits), longint'(ec));
    check(sumCsd(csdDigits) == int'($signed(w)), "R3 csd value",
          longint'(sumCsd(csdDigits)), longint'($signed(w)));
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
      if (inject && n == 5) begin
        actIn = ~a; wgtIn = w + 8'd3; chain = ~ch; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(n == 32, "R4 latency", longint'(n), 32);
    check(accOut == 20'(expAcc), ch ? "R6 chained sum" : "R4 product",
          longint'(accOut), expAcc);
    check(int'(eventCnt) == expEv, "R5 event count", longint'(eventCnt), longint'(expEv));
    if (inject) begin
      check(boothDigits == eb && csdDigits == ec, "R7 digits kept",
            longint'(boothDigits), longint'(eb));
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 done one cycle", longint'(done), 0);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0, "R1 reset flags", longint'({busy, done}), 0);
    check(accOut == 0 && eventCnt == 0, "R1 reset result", longint'(accOut), 0);
    check(boothDigits == 0 && csdDigits == 0, "R1 reset digits",
          longint'(csdDigits), 0);
  endtask

  task automatic testCorners();
    runMac(8'd0, 8'd77, 1'b0, 1'b0);       // R5 zero activation
    check(eventCnt == 0, "R5 zero operand no events", longint'(eventCnt), 0);
    runMac(8'd127, 8'd127, 1'b0, 1'b0);
    runMac(8'h80, 8'h80, 1'b0, 1'b0);      // -128 * -128
    runMac(8'h80, 8'd127, 1'b0, 1'b0);
    runMac(8'd85, 8'hAA, 1'b0, 1'b0);
    runMac(8'd91, 8'hFF, 1'b0, 1'b0);
    runMac(8'hFF, 8'd0, 1'b0, 1'b0);       // R5 zero weight
  endtask

  task automatic testHold();
    logic signed [19:0] keep = accOut;
    logic [5:0] keepEv = eventCnt;
    @(negedge clk);
    actIn = 8'h3C; wgtIn = 8'hC3;
    repeat (6) @(negedge clk);
    check(accOut == keep && eventCnt == keepEv, "R8 hold while idle",
          longint'(accOut), longint'(keep));
  endtask

  task automatic testChain();
    runMac(8'd10, 8'd20, 1'b0, 1'b0);
    runMac(8'hF6, 8'd7, 1'b1, 1'b0);
    runMac(8'd100, 8'h9C, 1'b1, 1'b0);
    runMac(8'h81, 8'h81, 1'b1, 1'b0);
  endtask

  task automatic testIgnore();
    runMac(8'd57, 8'hD3, 1'b0, 1'b1);
    runMac(8'hB5, 8'd46, 1'b1, 1'b1);
  endtask

  task automatic testRandom();
    for (int t = 0; t < 40; t++) begin
      logic [31:0] r = $urandom;
      runMac(r[7:0], r[15:8], r[16], 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCorners();
    testHold();
    testChain();
    testIgnore();
    testRandom();
    summary();
    $finish;
  end
endmodule